// File: doc/BRIEF.md
# Vectored Interrupt Priority Tracker

This block keeps the interrupt state of one interrupt controller across 256 vectors. It holds three bitmaps: pending, in-service and trigger-mode. It also holds a task priority value. Requests come in with a vector number and a flag that marks them as level- or edge-triggered. The block always presents the highest pending vector. It raises a deliverable flag only when that vector's priority class beats the class of the highest vector already in service.

The consumer takes the presented vector with an acknowledge strobe, which moves the vector from pending to in-service. When the handler finishes, the consumer pulses end-of-interrupt, which retires the highest in-service vector. If the retired vector was level-triggered, the block emits a one-cycle broadcast that carries the vector number, so that the source can re-sample its line. A processor priority value is always readable. It combines the task priority with the class of the highest vector in service.

Top module: `vec_prio_tracker`

## Requirements
- R1: Vector v is held at bit v mod 32 of word v/32 of each bitmap. A request for any vector from 0x00 to 0xFF becomes visible on `irq_vec` once it is the highest pending vector.
- R2: `irq_vec` always shows the highest-numbered pending vector, found by searching from the top word down. When nothing is pending, `irq_pending` is 0.
- R3: `ppr` equals the 8-bit task priority when its bits 7:4 are at least the class (bits 7:4) of the highest in-service vector. Otherwise `ppr` is that class followed by four zero bits. An empty in-service set counts as class 0.
- R4: `irq_pending` is 1 only when `enable` is 1, at least one vector is pending, and bits 7:4 of the highest pending vector are strictly greater than the highest in-service class (0 when none is in service).
- R5: An `ack` while `irq_pending` is 1 sets the in-service bit of `irq_vec` and clears its pending bit, taking effect at the next clock edge. An `ack` while `irq_pending` is 0 does nothing.
- R6: An `eoi` clears the highest in-service bit. If that vector's trigger-mode bit is set, the bit is cleared and `eoi_bc_valid` pulses for exactly one cycle after the edge, with `eoi_bc_vec` set to the vector. An edge-triggered vector causes no pulse.
- R7: An `eoi` with nothing in service changes no state and produces no broadcast.
- R8: A request with `req_level` set to 1 also sets the vector's trigger-mode bit. A level request for a vector that is already pending is dropped, and `req_accepted` is 0. An edge request for a vector that is already pending reports `req_accepted` as 1.
- R9: While `enable` is 0, requests are ignored and `req_accepted` is 0.
- R10: A task priority write keeps only bits 7:0 of `tpr_wdata`.
- R11: When a request and an acknowledge name the same vector in the same cycle, the request wins: the pending bit stays set while the in-service bit is also set.
- R12: Reset clears all three bitmaps and the task priority, so `irq_pending`, `ppr` and `eoi_bc_valid` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Software enable of the controller |
| req | input | 1 | Interrupt request strobe |
| req_vec | input | 8 | Requested vector |
| req_level | input | 1 | 1 = level-triggered, 0 = edge-triggered |
| req_accepted | output | 1 | The request in this cycle is taken |
| ack | input | 1 | Acknowledge the presented vector |
| irq_pending | output | 1 | A deliverable interrupt exists |
| irq_vec | output | 8 | Highest pending vector |
| eoi | input | 1 | End-of-interrupt strobe |
| eoi_bc_valid | output | 1 | Broadcast pulse for a level-triggered completion |
| eoi_bc_vec | output | 8 | Vector of the broadcast |
| tpr_we | input | 1 | Task priority write strobe |
| tpr_wdata | input | 32 | Task priority write data |
| ppr | output | 8 | Processor priority |

## Verification
The bench builds the block with its default parameters: 8-bit vectors held in 32-bit words, which gives eight words. With these values the search can be exercised in several ways: vector 0xFF in the top word, class-0 vectors in the bottom word, and requests that jump between words in both directions. The default width also allows the in-service class and the pending class to be equal, which is the strict-compare boundary of the deliverable flag.

// File: rtl/vec_prio_tracker.sv
module vec_prio_tracker #(
  parameter int VEC_W  = 8,
  parameter int WORD_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic             req,
  input  logic [VEC_W-1:0] req_vec,
  input  logic             req_level,
  output logic             req_accepted,
  input  logic             ack,
  output logic             irq_pending,
  output logic [VEC_W-1:0] irq_vec,
  input  logic             eoi,
  output logic             eoi_bc_valid,
  output logic [VEC_W-1:0] eoi_bc_vec,
  input  logic             tpr_we,
  input  logic [31:0]      tpr_wdata,
  output logic [VEC_W-1:0] ppr
);
  localparam int NVEC  = 1 << VEC_W;
  localparam int NWORD = NVEC / WORD_W;
  localparam int BIT_W = $clog2(WORD_W);
  localparam int CLS_W = 4;

  typedef logic [NWORD-1:0][WORD_W-1:0] map_t;

  map_t irr_q, isr_q, tmr_q, irr_n, isr_n, tmr_n;
  logic [VEC_W-1:0] tpr_q;
  logic bc_n;

  function automatic logic [VEC_W:0] find_top(input map_t m);
    logic [VEC_W:0] r;
    r = '0;
    for (int w = NWORD - 1; w >= 0; w--) begin
      if (!r[VEC_W] && m[w] != '0) begin
        for (int b = 0; b < WORD_W; b++)
          if (m[w][b]) r = {1'b1, VEC_W'(w * WORD_W + b)};
      end
    end
    return r;
  endfunction

  logic [VEC_W:0] irr_top, isr_top;
  logic [CLS_W-1:0] isr_cls, irr_cls;

  assign irr_top = find_top(irr_q);
  assign isr_top = find_top(isr_q);
  assign irq_vec = irr_top[VEC_W-1:0];
  assign irr_cls = irr_top[VEC_W-1 -: CLS_W];
  assign isr_cls = isr_top[VEC_W] ? isr_top[VEC_W-1 -: CLS_W] : '0;

  assign irq_pending = enable && irr_top[VEC_W] && (irr_cls > isr_cls);
  assign ppr = (tpr_q[VEC_W-1 -: CLS_W] >= isr_cls) ? tpr_q
             : {isr_cls, {(VEC_W-CLS_W){1'b0}}};

  wire [VEC_W-BIT_W-1:0] rw = req_vec[VEC_W-1:BIT_W];
  wire [BIT_W-1:0]       rb = req_vec[BIT_W-1:0];
  wire [VEC_W-BIT_W-1:0] aw = irq_vec[VEC_W-1:BIT_W];
  wire [BIT_W-1:0]       ab = irq_vec[BIT_W-1:0];
  wire [VEC_W-BIT_W-1:0] ew = isr_top[VEC_W-1:BIT_W];
  wire [BIT_W-1:0]       eb = isr_top[BIT_W-1:0];

  assign req_accepted = req && enable && !(req_level && irr_q[rw][rb]);

  always_comb begin
    irr_n = irr_q;
    isr_n = isr_q;
    tmr_n = tmr_q;
    bc_n  = 1'b0;
    if (ack && irq_pending) begin
      isr_n[aw][ab] = 1'b1;
      irr_n[aw][ab] = 1'b0;
    end
    if (eoi && isr_top[VEC_W]) begin
      isr_n[ew][eb] = 1'b0;
      if (tmr_q[ew][eb]) begin
        tmr_n[ew][eb] = 1'b0;
        bc_n = 1'b1;
      end
    end
    if (req_accepted) begin
      irr_n[rw][rb] = 1'b1;
      if (req_level) tmr_n[rw][rb] = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irr_q        <= '0;
      isr_q        <= '0;
      tmr_q        <= '0;
      tpr_q        <= '0;
      eoi_bc_valid <= 1'b0;
      eoi_bc_vec   <= '0;
    end else begin
      irr_q        <= irr_n;
      isr_q        <= isr_n;
      tmr_q        <= tmr_n;
      eoi_bc_valid <= bc_n;
      if (bc_n) eoi_bc_vec <= isr_top[VEC_W-1:0];
      if (tpr_we) tpr_q <= tpr_wdata[VEC_W-1:0];
    end
  end

  // R6
  bc_after_eoi_chk: assert property (@(posedge clk) disable iff (!rst_n)
    eoi_bc_valid |-> $past(eoi));

  // R5
  ack_raises_ppr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && irq_pending) |=> (ppr[VEC_W-1 -: CLS_W] >= $past(irq_vec[VEC_W-1 -: CLS_W])));

  // R9
  dis_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |-> !req_accepted);

  // R3
  ppr_floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ppr >= tpr_q);

  // R4
  pend_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_pending |-> (enable && irr_q != '0));
endmodule

// File: tb/sim_vec_prio_tracker.sv
module sim_vec_prio_tracker;
  logic clk = 0, rst_n = 0, enable = 1;
  logic req = 0, req_level = 0, ack = 0, eoi = 0, tpr_we = 0;
  logic [7:0] req_vec = 0;
  logic [31:0] tpr_wdata = 0;
  logic req_accepted, irq_pending, eoi_bc_valid;
  logic [7:0] irq_vec, eoi_bc_vec, ppr;
  int n_chk = 0, n_bad = 0;

  always #2.5 clk = ~clk;

  vec_prio_tracker u0 (
    .clk(clk), .rst_n(rst_n), .enable(enable), .req(req), .req_vec(req_vec),
    .req_level(req_level), .req_accepted(req_accepted), .ack(ack),
    .irq_pending(irq_pending), .irq_vec(irq_vec), .eoi(eoi),
    .eoi_bc_valid(eoi_bc_valid), .eoi_bc_vec(eoi_bc_vec), .tpr_we(tpr_we),
    .tpr_wdata(tpr_wdata), .ppr(ppr)
  );

  // {request vector, expected top vector, expected deliverable}
  localparam logic [16:0] TBL [7] = '{
    {8'h05, 8'h05, 1'b0}, {8'h31, 8'h31, 1'b1}, {8'h10, 8'h31, 1'b1},
    {8'hE5, 8'hE5, 1'b1}, {8'h7F, 8'hE5, 1'b1}, {8'hFF, 8'hFF, 1'b1},
    {8'h20, 8'hFF, 1'b1}
  };

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); #1;
    req = 0; req_level = 0; ack = 0; eoi = 0; tpr_we = 0;
  endtask

  task automatic do_req(logic [7:0] v, logic lvl);
    req = 1; req_vec = v; req_level = lvl; step();
  endtask

  task automatic do_reset();
    rst_n = 0; #12; rst_n = 1; step();
  endtask

  initial begin
    #100000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: got 0 expected 1");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    do_reset();
    chk("R12 pending", irq_pending, 0);
    chk("R12 ppr", ppr, 0);
    chk("R12 bcast", eoi_bc_valid, 0);

    // R1 R2 R4 table walk
    for (int i = 0; i < 7; i++) begin
      do_req(TBL[i][16:9], 1'b0);
      chk("R1/R2 top", irq_vec, TBL[i][8:1]);
      chk("R4 pend", irq_pending, TBL[i][0]);
    end
    do_reset();
    chk("R12 cleared", irq_pending, 0);

    // R9
    enable = 0; req = 1; req_vec = 8'h40; #1;
    chk("R9 accepted", req_accepted, 0);
    step(); enable = 1; #1;
    chk("R9 ignored", irq_pending, 0);

    // R10
    tpr_we = 1; tpr_wdata = 32'hABCD_1234; step();
    chk("R10 tpr", ppr, 8'h34);

    // R5 R3
    do_req(8'h61, 1'b1);
    chk("R4 pend 61", irq_pending, 1);
    ack = 1; step();
    chk("R5 pend cleared", irq_pending, 0);
    chk("R3 ppr isr", ppr, 8'h60);
    ack = 1; step();
    chk("R5 idle ack", ppr, 8'h60);
    do_req(8'h65, 1'b1);
    chk("R4 equal class", irq_pending, 0);
    chk("R2 vec 65", irq_vec, 8'h65);
    do_req(8'h71, 1'b0);
    chk("R4 higher class", irq_pending, 1);
    ack = 1; step();
    chk("R3 ppr 70", ppr, 8'h70);
    chk("R2 back to 65", irq_vec, 8'h65);
    eoi = 1; step();
    chk("R6 edge no bcast", eoi_bc_valid, 0);
    chk("R6 ppr 60", ppr, 8'h60);
    eoi = 1; step();
    chk("R6 bcast", eoi_bc_valid, 1);
    chk("R6 bcast vec", eoi_bc_vec, 8'h61);
    chk("R3 ppr tpr", ppr, 8'h34);
    chk("R4 pend 65", irq_pending, 1);
    step();
    chk("R6 one pulse", eoi_bc_valid, 0);

    // R8
    req = 1; req_vec = 8'h65; req_level = 1; #1;
    chk("R8 level dup", req_accepted, 0);
    req_level = 0; #1;
    chk("R8 edge dup", req_accepted, 1);
    step();

    // R11
    req = 1; req_vec = 8'h65; ack = 1; step();
    chk("R11 still pending", irq_vec, 8'h65);
    chk("R11 in service", ppr, 8'h60);
    chk("R11 not deliverable", irq_pending, 0);

    // R7
    eoi = 1; step();
    chk("R6 level bcast", eoi_bc_valid, 1);
    chk("R6 level vec", eoi_bc_vec, 8'h65);
    eoi = 1; step();
    chk("R7 no bcast", eoi_bc_valid, 0);
    chk("R7 ppr kept", ppr, 8'h34);
    chk("R7 pend kept", irq_pending, 1);

    tpr_we = 1; tpr_wdata = 32'h0000_00F0; step();
    chk("R3 tpr high", ppr, 8'hF0);

    do_reset();
    chk("R12 ppr reset", ppr, 0);
    chk("R12 pend reset", irq_pending, 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule